// File: doc/BRIEF.md
# Dual-Slot Conversion Result Controller

This block is the digital control shell around one sampling converter. It keeps two independent conversion slots, A and B. Each slot holds an input-channel select, an interrupt enable, a conversion-complete flag and a 12-bit unsigned result, so a full-scale input reads back as 4095. An external trigger sequencer fires a slot A or slot B pre-trigger pulse. The block converts the channel named by that slot and writes the sample into that slot's result register. It then raises the slot's complete flag and pulses a per-slot completion output. The sequencer can use the slot A completion pulse to launch slot B back-to-back, and it watches the busy output to detect its own sequencing errors.

The converter itself is modelled as a fixed-latency stub. It captures the selected analog lane when a conversion starts and returns that value a parameterised number of cycles later. Software reaches the slots through a plain register read/write port with a combinational read path. Reading a slot's result clears that slot's complete flag. Software can enable the interrupt on slot B alone, so that one interrupt marks the end of a full A-then-B sequence.

A state machine with three states sequences the conversions: `ST_IDLE`, `ST_CONV_A` and `ST_CONV_B`. It has five named transitions. In hardware mode, T_HW_A (pre-trigger A) and T_HW_B (pre-trigger B) lead from `ST_IDLE` into the matching converting state. In software mode, T_SW_A (a write to slot A control) leads from `ST_IDLE` to `ST_CONV_A`. T_DONE_A and T_DONE_B (converter result valid) lead from the converting state back to `ST_IDLE`.

Top module: `dsc_dual_slot_adc`

## Requirements
- R1: Register map, by word address on `bus_addr`. Address 0 is slot A control and address 1 is slot B control: channel in bits [CH_W-1:0], interrupt enable in bit 8, both readable. Address 2 is slot A result and address 3 is slot B result, read-only and zero-extended. Address 4 is status: bit 0 complete A, bit 1 complete B, bit 2 busy, bit 3 hardware-trigger mode. A write to address 4 sets the mode from bit 3 (1 = hardware triggers, 0 = software trigger).
- R2: After reset, every control field, flag and result is zero, the mode is software, and `busy`, `done_a`, `done_b` and `irq` are low.
- R3: In hardware mode, a pre-trigger seen at a clock edge while idle starts a conversion at that edge. Slot A's pre-trigger uses slot A's channel and slot B's uses slot B's. The lane value sampled at that edge is what appears in the matching result register, even if the lane changes later.
- R4: A conversion accepted at edge E keeps `busy` high for exactly LATENCY cycles (LATENCY ≥ 1). The result, complete flag and completion pulse appear at edge E+LATENCY.
- R5: A pre-trigger that arrives while busy is ignored. If both pre-triggers arrive at the same idle edge, slot A is started and slot B is ignored.
- R6: Reading a slot's result register clears that slot's complete flag and its interrupt contribution. If a new result is stored at the same edge as the read, the flag stays set.
- R7: `irq` is high whenever some slot has both its complete flag and its interrupt enable set. With the enable set only on slot B, `irq` stays low after the A conversion and rises after the B conversion.
- R8: `done_a` or `done_b` pulses high for one cycle right after that slot's result is stored, and never both at once. A slot B pre-trigger driven during the `done_a` cycle is accepted at the next edge.
- R9: In software mode, pre-triggers and writes to slot B control start nothing. A write to slot A control while idle starts a conversion at the write edge, using the channel carried in that same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data (combinational) |
| pretrig_a | input | 1 | Slot A hardware start pulse |
| pretrig_b | input | 1 | Slot B hardware start pulse |
| ain | input | NUM_CH*RES_W | Analog lane samples, lane k in bits [k*RES_W +: RES_W] |
| busy | output | 1 | Conversion in progress |
| done_a | output | 1 | Slot A result stored (one-cycle pulse) |
| done_b | output | 1 | Slot B result stored (one-cycle pulse) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with four lanes, 12-bit results and a LATENCY of 5. The short latency lets it place a read exactly on the completion edge and fire a second pre-trigger inside the busy window within a handful of cycles. It also lets a full A-then-B chain, started from the `done_a` pulse, complete quickly. Lane values include 0 and the full-scale value 4095, and one lane is changed while its conversion is in flight, which exposes any late sampling.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONV_A = 2'd1,
        ST_CONV_B = 2'd2
    } conv_state_e;

    // Word addresses
    localparam int ADR_CTL_A = 0;
    localparam int ADR_CTL_B = 1;
    localparam int ADR_RES_A = 2;
    localparam int ADR_RES_B = 3;
    localparam int ADR_STAT  = 4;

    // Field positions
    localparam int IE_BIT        = 8;
    localparam int STAT_COCO_A   = 0;
    localparam int STAT_COCO_B   = 1;
    localparam int STAT_BUSY     = 2;
    localparam int STAT_HW_MODE  = 3;

endpackage

// File: rtl/dsc_conv_stub.sv
module dsc_conv_stub #(
    parameter int NUM_CH  = 4,
    parameter int RES_W   = 12,
    parameter int LATENCY = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W  = $clog2(LATENCY + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CH_W-1:0]         ch,
    input  logic [NUM_CH*RES_W-1:0] ain,
    output logic                    busy,
    output logic                    valid,
    output logic [RES_W-1:0]        data
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    logic [RES_W-1:0] lane [NUM_CH];
    logic [RES_W-1:0] picked;
    logic [CNT_W-1:0] cnt_q;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        assign lane[k] = ain[k*RES_W +: RES_W];
    end

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (int'(ch) == k) picked = lane[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            data  <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= CNT_LOAD;
            data  <= picked;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign valid = busy && (cnt_q == '0);

    // R5: the sequencer never restarts the converter mid-conversion
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R4: the countdown stays inside the latency window
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt_q) < LATENCY));

endmodule

// File: rtl/dsc_slot_regs.sv
module dsc_slot_regs #(
    parameter int CH_W  = 2,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic             cfg_ie,
    input  logic             res_we,
    input  logic [RES_W-1:0] res_data,
    input  logic             rd_clr,
    output logic [CH_W-1:0]  ch,
    output logic             ie,
    output logic             coco,
    output logic [RES_W-1:0] result,
    output logic             done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch <= '0;
            ie <= 1'b0;
        end else if (cfg_we) begin
            ch <= cfg_ch;
            ie <= cfg_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            coco   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= res_we;
            if (res_we) begin
                result <= res_data;
                coco   <= 1'b1;
            end else if (rd_clr) begin
                coco   <= 1'b0;
            end
        end
    end

    // R6: a result read with no new store drops the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !res_we) |=> !coco);

    // R6: a store at the read edge keeps the flag
    a_r6_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> coco);

    // R8: completion pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dsc_seq_fsm.sv
module dsc_seq_fsm
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_mode,
    input  logic pre_a,
    input  logic pre_b,
    input  logic sw_start,
    input  logic conv_valid,
    output logic start,
    output logic start_b,
    output logic busy,
    output logic wr_a,
    output logic wr_b
);

    conv_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hw_mode) begin
                    if (pre_a)      state_d = ST_CONV_A;   // T_HW_A
                    else if (pre_b) state_d = ST_CONV_B;   // T_HW_B
                end else if (sw_start) begin
                    state_d = ST_CONV_A;                   // T_SW_A
                end
            end
            ST_CONV_A: if (conv_valid) state_d = ST_IDLE;  // T_DONE_A
            ST_CONV_B: if (conv_valid) state_d = ST_IDLE;  // T_DONE_B
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start   = 1'b0;
        start_b = 1'b0;
        busy    = 1'b0;
        wr_a    = 1'b0;
        wr_b    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start   = (state_d != ST_IDLE);
                start_b = (state_d == ST_CONV_B);
            end
            ST_CONV_A: begin
                busy = 1'b1;
                wr_a = conv_valid;
            end
            ST_CONV_B: begin
                busy = 1'b1;
                wr_b = conv_valid;
            end
            default: ;
        endcase
    end

    // R4: an accepted start makes the block busy on the next cycle
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: in software mode nothing but a slot A write leaves idle
    a_r9_sw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hw_mode && !sw_start) |=> !busy);

    // R5: simultaneous pre-triggers favour slot A
    a_r5_a_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hw_mode && pre_a) |=> (state_q == ST_CONV_A));

endmodule

// File: rtl/dsc_dual_slot_adc.sv
module dsc_dual_slot_adc
    import dsc_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int RES_W   = 12,
    parameter int LATENCY = 8,
    parameter int BUS_W   = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [BUS_W-1:0]        bus_rdata,
    input  logic                    pretrig_a,
    input  logic                    pretrig_b,
    input  logic [NUM_CH*RES_W-1:0] ain,
    output logic                    busy,
    output logic                    done_a,
    output logic                    done_b,
    output logic                    irq
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NSLOT = 2;

    logic wr_hit, rd_hit;
    logic [NSLOT-1:0] cfg_we, res_we, rd_clr, coco, ie, done;
    logic [CH_W-1:0]  ch  [NSLOT];
    logic [RES_W-1:0] res [NSLOT];
    logic             hw_mode_q;
    logic             conv_start, start_b, conv_valid, stub_busy;
    logic [CH_W-1:0]  conv_ch;
    logic [RES_W-1:0] conv_data;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    // Slot register sets
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign cfg_we[g] = wr_hit && (bus_addr == ADDR_W'(ADR_CTL_A + g));
        assign rd_clr[g] = rd_hit && (bus_addr == ADDR_W'(ADR_RES_A + g));

        dsc_slot_regs #(
            .CH_W  (CH_W),
            .RES_W (RES_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[g]),
            .cfg_ch   (bus_wdata[CH_W-1:0]),
            .cfg_ie   (bus_wdata[IE_BIT]),
            .res_we   (res_we[g]),
            .res_data (conv_data),
            .rd_clr   (rd_clr[g]),
            .ch       (ch[g]),
            .ie       (ie[g]),
            .coco     (coco[g]),
            .result   (res[g]),
            .done     (done[g])
        );
    end

    // Trigger mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hw_mode_q <= 1'b0;
        else if (wr_hit && (bus_addr == ADDR_W'(ADR_STAT)))
            hw_mode_q <= bus_wdata[STAT_HW_MODE];
    end

    dsc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_mode    (hw_mode_q),
        .pre_a      (pretrig_a),
        .pre_b      (pretrig_b),
        .sw_start   (cfg_we[0]),
        .conv_valid (conv_valid),
        .start      (conv_start),
        .start_b    (start_b),
        .busy       (busy),
        .wr_a       (res_we[0]),
        .wr_b       (res_we[1])
    );

    // Software start takes the channel from the write in flight
    assign conv_ch = !hw_mode_q ? bus_wdata[CH_W-1:0]
                   : (start_b ? ch[1] : ch[0]);

    dsc_conv_stub #(
        .NUM_CH  (NUM_CH),
        .RES_W   (RES_W),
        .LATENCY (LATENCY)
    ) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .ch    (conv_ch),
        .ain   (ain),
        .busy  (stub_busy),
        .valid (conv_valid),
        .data  (conv_data)
    );

    // Read path
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_CTL_A: begin
                bus_rdata[CH_W-1:0] = ch[0];
                bus_rdata[IE_BIT]   = ie[0];
            end
            ADR_CTL_B: begin
                bus_rdata[CH_W-1:0] = ch[1];
                bus_rdata[IE_BIT]   = ie[1];
            end
            ADR_RES_A: bus_rdata[RES_W-1:0] = res[0];
            ADR_RES_B: bus_rdata[RES_W-1:0] = res[1];
            ADR_STAT: begin
                bus_rdata[STAT_COCO_A]  = coco[0];
                bus_rdata[STAT_COCO_B]  = coco[1];
                bus_rdata[STAT_BUSY]    = busy;
                bus_rdata[STAT_HW_MODE] = hw_mode_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign done_a = done[0];
    assign done_b = done[1];
    assign irq    = |(coco & ie);

    // R4: sequencer and converter agree on busy
    a_r4_busy_agree: assert property (@(posedge clk) disable iff (!rst_n)
        busy == stub_busy);

    // R8: at most one completion pulse per cycle
    a_r8_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_a, done_b}));

    // R7: no interrupt without a pending flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (coco[0] || coco[1]));

endmodule

// File: tb/tb_dsc_dual_slot_adc.sv
module tb_dsc_dual_slot_adc;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 4;
    localparam int RES_W  = 12;
    localparam int LAT    = 5;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;

    localparam int A_CTLA = 0, A_CTLB = 1, A_RESA = 2, A_RESB = 3, A_STAT = 4;
    localparam int IE     = 32'h100;
    localparam int HWMODE = 32'h8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic pretrig_a = 1'b0, pretrig_b = 1'b0;
    logic [NUM_CH*RES_W-1:0] ain = '0;
    logic busy, done_a, done_b, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct { int slot; int when; } exp_t;
    exp_t sbq[$];

    dsc_dual_slot_adc #(
        .NUM_CH(NUM_CH), .RES_W(RES_W), .LATENCY(LAT), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pretrig_a(pretrig_a), .pretrig_b(pretrig_b), .ain(ain),
        .busy(busy), .done_a(done_a), .done_b(done_b), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected completion per pulse
    always @(negedge clk) begin
        if (rst_n && (done_a || done_b)) begin
            if (sbq.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R5/R8 unexpected completion: actual a=%0d b=%0d expected none",
                         done_a, done_b);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R8 completion slot", done_b ? 1 : 0, e.slot);
                chk("R4 completion cycle", cyc, e.when);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic set_lane(input int k, input int v);
        ain[k*RES_W +: RES_W] = RES_W'(v);
    endtask

    task automatic bus_write(input int adr, input int data, output int edge_n);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(adr); bus_wdata = BUS_W'(data);
        @(posedge clk); #1;
        edge_n = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int adr, output int data);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(adr);
        @(negedge clk);
        data = int'(bus_rdata);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input bit a, input bit b, output int edge_n);
        pretrig_a = a; pretrig_b = b;
        @(posedge clk); #1;
        edge_n = cyc;
        pretrig_a = 1'b0; pretrig_b = 1'b0;
    endtask

    task automatic expect_done(input int slot, input int edge_n);
        exp_t e;
        e.slot = slot; e.when = edge_n + LAT;
        sbq.push_back(e);
    endtask

    // Counts busy cycles over the next LAT+3 cycles
    task automatic busy_len(output int n);
        n = 0;
        for (int k = 0; k < LAT + 3; k++) begin
            @(negedge clk);
            if (busy) n++;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int e0, e1, v, n;
        set_lane(0, 12'h123);
        set_lane(1, 12'hFFF);
        set_lane(2, 12'h07E);
        set_lane(3, 12'h000);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R2 reset state
        @(negedge clk);
        chk("R2 busy", busy, 0);
        chk("R2 irq", irq, 0);
        chk("R2 done", {done_a, done_b}, 0);
        step();
        bus_read(A_STAT, v); chk("R2 status", v, 0);
        bus_read(A_RESA, v); chk("R2 result A", v, 0);
        bus_read(A_CTLB, v); chk("R2 control B", v, 0);

        // R1 configuration readback
        bus_write(A_STAT, HWMODE, e0);
        bus_write(A_CTLA, 1, e0);
        bus_write(A_CTLB, IE | 2, e0);
        bus_read(A_CTLA, v); chk("R1 control A", v, 1);
        bus_read(A_CTLB, v); chk("R1 control B", v, IE | 2);
        bus_read(A_STAT, v); chk("R1 status mode", v, HWMODE);

        // R3/R4: slot A, lane changed mid-conversion
        pulse(1'b1, 1'b0, e0);
        expect_done(0, e0);
        set_lane(1, 12'h555);
        busy_len(n);
        chk("R4 busy length", n, LAT);
        chk("R7 irq low, A has no enable", irq, 0);
        bus_read(A_STAT, v); chk("R3 flag A set", v, HWMODE | 1);
        bus_read(A_RESA, v); chk("R3 full-scale sample at start", v, 12'hFFF);
        bus_read(A_STAT, v); chk("R6 flag A cleared", v, HWMODE);
        set_lane(1, 12'hFFF);

        // R8/R7: chained A then B
        pulse(1'b1, 1'b0, e0);
        expect_done(0, e0);
        n = 0;
        do begin @(negedge clk); n++; end while (!done_a && n < 50);
        chk("R7 irq low after A only", irq, 0);
        pretrig_b = 1'b1;
        @(posedge clk); #1;
        e1 = cyc;
        pretrig_b = 1'b0;
        expect_done(1, e1);
        chk("R8 chained B accepted", e1, e0 + LAT + 1);
        repeat (LAT + 2) step();
        @(negedge clk);
        chk("R7 irq high after B", irq, 1);
        step();
        bus_read(A_RESA, v); chk("R3 result A", v, 12'hFFF);
        bus_read(A_RESB, v); chk("R3 result B", v, 12'h07E);
        @(negedge clk);
        chk("R6 irq cleared by B read", irq, 0);
        step();

        // R5: pre-trigger while busy
        pulse(1'b1, 1'b0, e0);
        expect_done(0, e0);
        step();
        pulse(1'b0, 1'b1, e1);
        repeat (LAT + 2) step();
        bus_read(A_STAT, v); chk("R5 busy B ignored", v, HWMODE | 1);
        bus_read(A_RESA, v);

        // R5: simultaneous pre-triggers
        pulse(1'b1, 1'b1, e0);
        expect_done(0, e0);
        busy_len(n);
        chk("R5 single conversion", n, LAT);
        bus_read(A_STAT, v); chk("R5 A wins", v, HWMODE | 1);
        bus_read(A_RESA, v);

        // R6: read on the completion edge
        pulse(1'b1, 1'b0, e0);
        expect_done(0, e0);
        repeat (LAT - 1) step();
        bus_read(A_RESA, v);
        bus_read(A_STAT, v); chk("R6 store beats read clear", v, HWMODE | 1);
        bus_read(A_RESA, v); chk("R6 result after collision", v, 12'hFFF);

        // R9: software mode
        bus_write(A_STAT, 0, e0);
        pulse(1'b1, 1'b1, e0);
        @(negedge clk);
        chk("R9 pretrig ignored", busy, 0);
        step();
        bus_write(A_CTLB, 3, e0);
        @(negedge clk);
        chk("R9 slot B write no start", busy, 0);
        step();
        bus_write(A_CTLA, IE | 0, e0);
        expect_done(0, e0);
        @(negedge clk);
        chk("R9 slot A write starts", busy, 1);
        step();
        repeat (LAT + 1) step();
        @(negedge clk);
        chk("R7 irq on A enable", irq, 1);
        step();
        bus_read(A_RESA, v); chk("R9 sample of written channel", v, 12'h123);
        bus_read(A_CTLB, v); chk("R1 control B readback", v, 3);

        repeat (4) step();
        chk("R8 all completions seen", sbq.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule